// File: doc/BRIEF.md
# Shuffle Register Add/Subtract Datapath

This block is a streaming arithmetic datapath. One 8-bit two's complement sample comes in and one 8-bit result goes out on every clock, with no stalls. Samples are written into a small bank of holding registers. Each register has its own load enable. An external sequencer drives the enables, two operand selects and an add/subtract bit. With those it decides, cycle by cycle, which stored value or which sum or difference of two stored values is sent to the output.

There are two operands. Operand A comes from the first multiplexer, which has a constant zero in the slot where the last register would be. Operand B comes from the second multiplexer, which reaches every register. The block computes B + A or B - A. Subtraction inverts A with XOR gates and feeds the control bit in as the carry-in of a ripple-carry adder. The adder result is registered before it leaves the block. With A set to the zero slot, the value of register B passes through unchanged.

The block has no state machine. It is a fixed datapath whose behaviour is set entirely by the control inputs in each cycle. There are therefore no states or transitions to name.

Top module: `shf_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears every holding register and `dout` to zero. `dout` reads 0 in the cycle after any clock edge at which `rst` was high.
- R2: Holding register i loads `din` at a clock edge only when `load_en[i]` is 1. Otherwise it keeps its value.
- R3: When `sel_a` equals NREG-1 (3 by default), operand A is the constant zero. With `sub`=0, `dout` becomes the value of register `sel_b`.
- R4: When `sub`=0 and `sel_a` is below NREG-1, `dout` becomes reg[`sel_b`] + reg[`sel_a`].
- R5: When `sub`=1 and `sel_a` is below NREG-1, `dout` becomes reg[`sel_b`] - reg[`sel_a`].
- R6: One result is produced per clock with a latency of one edge. The result registered at edge k uses the register contents held just before edge k. A sample loaded at edge k therefore first appears in the result of edge k+1.
- R7: All arithmetic wraps modulo 256, with no saturation. For example, 0x7F + 0x01 gives 0x80 and 0x80 - 0x01 gives 0x7F.
- R8: When `sel_a` selects the zero slot and `sub`=1, `dout` is still the value of register `sel_b`.
- R9: When `sel_a` equals `sel_b` (below NREG-1), subtraction gives 0 and addition gives twice the register value, modulo 256.
- R10: When several load enables are high at the same edge, every enabled register captures the same `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 8 | Incoming two's complement sample |
| load_en | input | 4 | Per-register load enables, bit i for register i |
| sel_a | input | 2 | Operand A select; value 3 is the constant zero |
| sel_b | input | 2 | Operand B select over all registers |
| sub | input | 1 | 0 selects B + A, 1 selects B - A |
| dout | output | 8 | Registered result |

## Verification
The bench aims at signed overflow in both directions. A design that saturated, or that inverted A without also feeding in the carry, would give 0x7F or 0x7E where 0x80 and 0x7F are expected. It pairs pass-through with `sub`=1 and subtracts a register from itself. A design missing the carry-in, or inverting operand B instead of A, would give 0xFF or a negated value there. It also writes a register in the same cycle that the register is selected. A design that forwarded `din` past the holding registers, or that shifted the bank instead of loading only the enabled entries, would show the new sample one cycle early or corrupt the registers it should have held.

// File: rtl/shf_pkg.sv
package shf_pkg;

    // Arithmetic operation selected by the sequencer's control bit.
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // Default geometry of the datapath.
    localparam int DEF_DW   = 8;
    localparam int DEF_NREG = 4;

endpackage

// File: rtl/shf_regbank.sv
module shf_regbank #(
    parameter int DW   = 8,
    parameter int NREG = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [DW-1:0]            din,
    input  logic [NREG-1:0]          load_en,
    output logic [NREG-1:0][DW-1:0]  q
);

    // One independently enabled holding register per slot.
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (load_en[i]) begin
                q[i] <= din;
            end
        end
    end

endmodule

// File: rtl/shf_opnd_mux.sv
module shf_opnd_mux #(
    parameter int DW       = 8,
    parameter int NREG     = 4,
    parameter int SELW     = 2,
    parameter bit HAS_ZERO = 1'b0
) (
    input  logic [NREG-1:0][DW-1:0] regs,
    input  logic [SELW-1:0]         sel,
    output logic [DW-1:0]           y
);

    localparam int ZSLOT = NREG - 1;

    if (HAS_ZERO) begin : g_zero_slot
        // The last slot is tied to zero instead of the last register.
        always_comb begin
            y = '0;
            for (int i = 0; i < ZSLOT; i++) begin
                if (sel == SELW'(i)) y = regs[i];
            end
        end
    end else begin : g_full
        always_comb begin
            y = '0;
            for (int i = 0; i < NREG; i++) begin
                if (sel == SELW'(i)) y = regs[i];
            end
        end
    end

endmodule

// File: rtl/shf_ripple_add.sv
module shf_ripple_add #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] s
);

    logic [DW:0] c;
    assign c[0] = cin;

    // Chain of full adders; carry ripples bit by bit.
    for (genvar i = 0; i < DW; i++) begin : g_fa
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
    import shf_pkg::*;
#(
    parameter int DW   = DEF_DW,
    parameter int NREG = DEF_NREG,
    localparam int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   din,
    input  logic [NREG-1:0] load_en,
    input  logic [SELW-1:0] sel_a,
    input  logic [SELW-1:0] sel_b,
    input  logic            sub,
    output logic [DW-1:0]   dout
);

    logic [NREG-1:0][DW-1:0] bank_q;
    logic [DW-1:0]           opnd_a;
    logic [DW-1:0]           opnd_b;
    logic [DW-1:0]           opnd_a_x;
    logic [DW-1:0]           sum;
    logic [DW-1:0]           dout_q;
    op_e                     op;

    assign op = op_e'(sub);

    shf_regbank #(.DW(DW), .NREG(NREG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .load_en (load_en),
        .q       (bank_q)
    );

    shf_opnd_mux #(.DW(DW), .NREG(NREG), .SELW(SELW), .HAS_ZERO(1'b1)) u_mux_a (
        .regs (bank_q),
        .sel  (sel_a),
        .y    (opnd_a)
    );

    shf_opnd_mux #(.DW(DW), .NREG(NREG), .SELW(SELW), .HAS_ZERO(1'b0)) u_mux_b (
        .regs (bank_q),
        .sel  (sel_b),
        .y    (opnd_b)
    );

    // Conditional one's complement of operand A; carry-in completes negation.
    assign opnd_a_x = opnd_a ^ {DW{op == OP_SUB}};

    shf_ripple_add #(.DW(DW)) u_add (
        .a   (opnd_a_x),
        .b   (opnd_b),
        .cin (op == OP_SUB),
        .s   (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) dout_q <= '0;
        else     dout_q <= sum;
    end

    assign dout = dout_q;

endmodule

// File: rtl/shf_datapath_chk.sv
module shf_datapath_chk #(
    parameter int DW   = 8,
    parameter int NREG = 4,
    parameter int SELW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [DW-1:0]   din,
    input logic [NREG-1:0] load_en,
    input logic [SELW-1:0] sel_a,
    input logic [SELW-1:0] sel_b,
    input logic            sub,
    input logic [DW-1:0]   dout
);

    localparam logic [SELW-1:0] ZSEL = SELW'(NREG - 1);

    logic [DW-1:0] shadow [NREG];
    logic [DW-1:0] ref_a;
    logic [DW-1:0] ref_b;
    logic          rst_q;
    logic          armed;

    // Independent shadow of the holding registers, built from the ports.
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            armed <= 1'b1;
            for (int i = 0; i < NREG; i++) shadow[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) if (load_en[i]) shadow[i] <= din;
        end
    end

    always_comb begin
        ref_a = shadow[sel_a];
        ref_b = shadow[sel_b];
    end

    // R1: output clear after a reset edge.
    always @(negedge clk) begin
        if (rst_q === 1'b1) p_reset_clears_r1: assert (dout == '0);
    end

    p_pass_zero_r3: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (sel_a == ZSEL && !sub) |=> dout == $past(ref_b));

    p_pass_zero_sub_r8: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (sel_a == ZSEL && sub) |=> dout == $past(ref_b));

    p_add_r4: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (sel_a != ZSEL && !sub) |=> dout == $past(ref_b + ref_a));

    p_sub_r5: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (sel_a != ZSEL && sub) |=> dout == $past(ref_b - ref_a));

    p_self_sub_r9: assert property (@(posedge clk) disable iff (rst || armed !== 1'b1)
        (sel_a != ZSEL && sel_a == sel_b && sub) |=> dout == '0);

endmodule

bind shf_datapath shf_datapath_chk #(.DW(DW), .NREG(NREG), .SELW(SELW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .load_en (load_en),
    .sel_a   (sel_a),
    .sel_b   (sel_b),
    .sub     (sub),
    .dout    (dout)
);

// File: tb/tb_shf_datapath.sv
`timescale 1ns/1ps
module tb_shf_datapath;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] din;
    logic [3:0] load_en;
    logic [1:0] sel_a;
    logic [1:0] sel_b;
    logic       sub;
    logic [7:0] dout;

    int n_run  = 0;
    int n_fail = 0;

    logic [7:0] mdl [4];
    logic [7:0] exp_q;

    always #5 clk = ~clk;

    shf_datapath dut (
        .clk(clk), .rst(rst), .din(din), .load_en(load_en),
        .sel_a(sel_a), .sel_b(sel_b), .sub(sub), .dout(dout)
    );

    // Apply inputs, advance one edge, update the behavioural model, compare.
    task automatic step(input logic r, input logic [7:0] d, input logic [3:0] le,
                        input logic [1:0] sa, input logic [1:0] sb, input logic s,
                        input string tag);
        logic [7:0] a;
        rst = r; din = d; load_en = le; sel_a = sa; sel_b = sb; sub = s;
        @(posedge clk);
        a = (sa == 2'd3) ? 8'h00 : mdl[sa];
        if (r) begin
            exp_q = 8'h00;
            for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        end else begin
            exp_q = s ? (mdl[sb] - a) : (mdl[sb] + a);
            for (int i = 0; i < 4; i++) if (le[i]) mdl[i] = d;
        end
        #1;
        n_run++;
        if (dout !== exp_q) begin
            n_fail++;
            $display("FAIL %s: dout=%02h expected=%02h", tag, dout, exp_q);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: timeout, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        rst = 1'b1; din = 8'h00; load_en = 4'h0; sel_a = 2'd3; sel_b = 2'd0; sub = 1'b0;
        #2;
        // R1: reset clears output and registers.
        step(1, 8'hAA, 4'hF, 2'd0, 2'd1, 0, "R1");
        step(1, 8'hAA, 4'hF, 2'd0, 2'd1, 0, "R1");
        for (int i = 0; i < 4; i++) step(0, 8'h00, 4'h0, 2'd3, 2'(i), 0, "R1");
        step(0, 8'h00, 4'h0, 2'd3, 2'd0, 0, "R1");

        // R2: individual loads.
        step(0, 8'h7F, 4'b0001, 2'd3, 2'd0, 0, "R2");
        step(0, 8'h01, 4'b0010, 2'd3, 2'd0, 0, "R2");
        step(0, 8'h80, 4'b0100, 2'd3, 2'd1, 0, "R2");
        step(0, 8'hFF, 4'b1000, 2'd3, 2'd2, 0, "R2");
        // R2: disabled registers hold while din changes.
        step(0, 8'h3C, 4'b0000, 2'd3, 2'd3, 0, "R2");
        for (int i = 0; i < 4; i++) step(0, 8'hC3, 4'b0000, 2'd3, 2'(i), 0, "R2");

        // R3 / R8: zero-slot pass-through with add and subtract.
        for (int i = 0; i < 4; i++) step(0, 8'h00, 4'h0, 2'd3, 2'(i), 0, "R3");
        for (int i = 0; i < 4; i++) step(0, 8'h00, 4'h0, 2'd3, 2'(i), 1, "R8");
        step(0, 8'h00, 4'h0, 2'd3, 2'd0, 0, "R8");

        // R4 / R7: 0x7F + 0x01 = 0x80; 0xFF + 0x80 wraps.
        step(0, 8'h00, 4'h0, 2'd1, 2'd0, 0, "R4");
        step(0, 8'h00, 4'h0, 2'd0, 2'd1, 0, "R7");
        step(0, 8'h00, 4'h0, 2'd2, 2'd3, 0, "R7");
        // R5 / R7: 0x80 - 0x01 = 0x7F; 0x01 - 0x7F.
        step(0, 8'h00, 4'h0, 2'd1, 2'd2, 1, "R5");
        step(0, 8'h00, 4'h0, 2'd0, 2'd1, 1, "R7");
        step(0, 8'h00, 4'h0, 2'd2, 2'd3, 1, "R5");
        // R9: same register on both operands.
        step(0, 8'h00, 4'h0, 2'd0, 2'd0, 1, "R9");
        step(0, 8'h00, 4'h0, 2'd0, 2'd0, 0, "R9");
        step(0, 8'h00, 4'h0, 2'd2, 2'd2, 0, "R9");

        // R6: write a register while selecting it; new value appears one edge later.
        step(0, 8'h11, 4'b0001, 2'd3, 2'd0, 0, "R6");
        step(0, 8'h22, 4'b0001, 2'd3, 2'd0, 0, "R6");
        step(0, 8'h00, 4'b0000, 2'd3, 2'd0, 0, "R6");

        // R10: broadcast load into all registers.
        step(0, 8'h55, 4'hF, 2'd3, 2'd1, 0, "R10");
        for (int i = 0; i < 4; i++) step(0, 8'h00, 4'h0, 2'd3, 2'(i), 0, "R10");

        // R6: long mixed stream, compared on every clock.
        for (int k = 0; k < 400; k++) begin
            step(0, 8'($urandom), 4'($urandom), 2'($urandom), 2'($urandom),
                 1'($urandom), "R6");
        end

        // R1: reset in mid-stream.
        step(1, 8'h99, 4'hF, 2'd0, 2'd1, 1, "R1");
        step(0, 8'h00, 4'h0, 2'd3, 2'd2, 0, "R1");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule